// File: doc/BRIEF.md
# Multi-format stereo PCM serial receiver

This block turns a serial audio data line into parallel stereo samples. It is a slave: an external bit clock and an external frame clock arrive as plain inputs. A system clock samples them through synchronizers and detects their edges. One shift engine serves four framing conventions. The framing code selects where the first data bit of each channel sits relative to the frame-clock edge.

A two-bit length code sets how many bits make up one sample. Each finished sample is presented MSB-aligned in a 32-bit word, with a one-cycle strobe for its channel. Bit clocks in a half-frame beyond the programmed length carry no data and are ignored. The framing code and the length code are expected to stay steady while a stream is running. The system clock must run at least four times faster than the bit clock.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset, `left_o` and `right_o` read zero and both strobes are low.
- R2: With `fmt_i` = 00 (left-aligned), the MSB is taken on the first rising bit-clock edge after any frame-clock change. Frame clock low marks the left channel and high marks the right channel.
- R3: With `fmt_i` = 01 (right-aligned), the LSB is the bit taken on the last rising bit-clock edge before a frame-clock change. The word is presented after that change, on the channel the frame clock indicated before it changed (low = left).
- R4: With `fmt_i` = 10 (I2S), the MSB is taken on the second rising bit-clock edge after any frame-clock change. The channel convention is the same as in R2.
- R5: With `fmt_i` = 11 (DSP), only a rising frame-clock edge starts a frame. The left MSB is taken on the first rising bit-clock edge after it when `dsp_late_i` = 0, and on the second when `dsp_late_i` = 1. The right MSB is taken on the bit right after the left LSB.
- R6: `len_sel_i` codes 00, 01, 10 and 11 select 16, 20, 24 and 32 bits per sample. A sample is presented in bits 31 down to 32-n, and the lower bits are zero.
- R7: Extra bit clocks in a half-frame beyond the sample length do not change the presented samples, whatever level the data line has during them.
- R8: Each finished sample gives exactly one single-cycle strobe on its channel. The two strobes are never high together, and each sample output holds its value between its strobes.
- R9: The bit clock, frame clock and data pass through a common two-stage synchronizer. Every rising bit-clock edge is seen exactly once, provided the system clock is at least 4 times the bit-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Frame / channel-select clock (asynchronous) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 00 left-aligned, 01 right-aligned, 10 I2S, 11 DSP |
| dsp_late_i | input | 1 | DSP sub-mode: 0 MSB on first edge, 1 on second |
| len_sel_i | input | 2 | Sample length: 16/20/24/32 bits |
| left_o | output | 32 | Left sample, MSB-aligned |
| left_valid_o | output | 1 | Left sample strobe |
| right_o | output | 32 | Right sample, MSB-aligned |
| right_valid_o | output | 1 | Right sample strobe |

## Verification
The bench builds the block with its default parameters: 32-bit sample container and two synchronizer stages. The bit clock runs at one sixth of the system clock. It sweeps every framing code, every length code and both DSP sub-modes. Each combination is run with half-frames only one bit longer than the sample and with 40-bit half-frames whose idle slots drive ones. This covers the tightest placement of the frame-clock edge and the rejection of idle bits. The expected samples are derived by masking and shifting the transmitted words.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned LEN_W    = $clog2(SAMPLE_W + 1);
  localparam int unsigned POS_W    = $clog2(2 * SAMPLE_W + 2);

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [LEN_W-1:0] word_len(input logic [1:0] code);
    case (code)
      2'd0:    return LEN_W'(16);
      2'd1:    return LEN_W'(20);
      2'd2:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer
  import pcm_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic [1:0]       fmt_i,
  input  logic             late_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             bit_rise_o,
  output logic             done_l_o,
  output logic             done_r_o,
  output logic             use_prev_o
);
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  logic             sck_q, ws_last_q, started_q;
  logic [POS_W-1:0] pos_q, pos_now, pos_next, off, rel, len_p, len_2;
  logic             trans, frame_start, in_word, hit_one, hit_two;
  logic             dl, dr, prev;
  fmt_e             fmt;

  assign fmt        = fmt_e'(fmt_i);
  assign bit_rise_o = sck_i & ~sck_q;
  assign trans      = ws_i ^ ws_last_q;

  always_comb begin
    frame_start = (fmt == FMT_DSP) ? (ws_i & ~ws_last_q) : trans;
    pos_now     = frame_start ? '0 : pos_q;
    pos_next    = (pos_now == POS_IDLE) ? POS_IDLE : pos_now + 1'b1;
    off         = POS_W'(((fmt == FMT_I2S) || ((fmt == FMT_DSP) && late_i)) ? 1 : 0);
    rel         = pos_now - off;
    len_p       = POS_W'(len_i);
    len_2       = {len_p[POS_W-2:0], 1'b0};
    in_word     = (pos_now != POS_IDLE) && (pos_now >= off);
    hit_one     = in_word && (rel == len_p - 1'b1);
    hit_two     = in_word && (rel == len_2 - 1'b1);
    dl = 1'b0; dr = 1'b0; prev = 1'b0;
    case (fmt)
      FMT_RJ: begin
        prev = 1'b1;
        dl   = trans & started_q & ~ws_last_q;
        dr   = trans & started_q &  ws_last_q;
      end
      FMT_DSP: begin
        dl = hit_one;
        dr = hit_two;
      end
      default: begin
        dl = hit_one & ~ws_i;
        dr = hit_one &  ws_i;
      end
    endcase
  end

  assign done_l_o   = bit_rise_o & dl;
  assign done_r_o   = bit_rise_o & dr;
  assign use_prev_o = prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      ws_last_q <= 1'b0;
      started_q <= 1'b0;
      pos_q     <= POS_IDLE;
    end else begin
      sck_q <= sck_i;
      if (bit_rise_o) begin
        ws_last_q <= ws_i;
        started_q <= started_q | trans;
        pos_q     <= pos_next;
      end
    end
  end

  AST_RISE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_rise_o |=> !bit_rise_o); // R9
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_l_o, done_r_o})); // R8
endmodule

// File: rtl/pcm_shift_core.sv
module pcm_shift_core
  import pcm_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_rise_i,
  input  logic                sd_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                done_l_i,
  input  logic                done_r_i,
  input  logic                use_prev_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic                left_valid_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                right_valid_o
);
  logic [SAMPLE_W-1:0] sh_q, word_new, word_sel, aligned, low_mask;
  logic [LEN_W-1:0]    pad;

  assign word_new = {sh_q[SAMPLE_W-2:0], sd_i};
  // right-aligned: last bit shifted before the frame edge is the LSB
  assign word_sel = use_prev_i ? sh_q : word_new;
  assign pad      = LEN_W'(SAMPLE_W) - len_i;
  assign aligned  = word_sel << pad;
  assign low_mask = {SAMPLE_W{1'b1}} >> len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q          <= '0;
      left_o        <= '0;
      right_o       <= '0;
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
    end else begin
      left_valid_o  <= done_l_i;
      right_valid_o <= done_r_i;
      if (bit_rise_i) sh_q    <= word_new;
      if (done_l_i)   left_o  <= aligned;
      if (done_r_i)   right_o <= aligned;
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_valid_o | right_valid_o) |=> !(left_valid_o | right_valid_o)); // R8
  AST_LEFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !left_valid_o |-> $stable(left_o)); // R8
  AST_RIGHT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !right_valid_o |-> $stable(right_o)); // R8
  AST_LEFT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_valid_o |-> ((left_o & low_mask) == '0)); // R6
  AST_RIGHT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_valid_o |-> ((right_o & low_mask) == '0)); // R6
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_i,
  input  logic                dsp_late_i,
  input  logic [1:0]          len_sel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic                left_valid_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                right_valid_o
);
  logic [2:0]       pins_s;
  logic [LEN_W-1:0] len;
  logic             rise, done_l, done_r, use_prev;

  assign len = word_len(len_sel_i);

  // one synchronizer for all three pins keeps them mutually aligned
  pcm_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (pins_s)
  );

  pcm_bit_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (pins_s[2]),
    .ws_i      (pins_s[1]),
    .fmt_i     (fmt_i),
    .late_i    (dsp_late_i),
    .len_i     (len),
    .bit_rise_o(rise),
    .done_l_o  (done_l),
    .done_r_o  (done_r),
    .use_prev_o(use_prev)
  );

  pcm_shift_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_rise_i   (rise),
    .sd_i         (pins_s[0]),
    .len_i        (len),
    .done_l_i     (done_l),
    .done_r_i     (done_r),
    .use_prev_i   (use_prev),
    .left_o       (left_o),
    .left_valid_o (left_valid_o),
    .right_o      (right_o),
    .right_valid_o(right_valid_o)
  );
endmodule

// File: tb/tb_pcm_serial_rx.sv
`timescale 1ns/1ps
module tb_pcm_serial_rx;
  localparam int HALF = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'd0, len_sel = 2'd0;
  logic        late = 1'b0;
  logic [31:0] left_o, right_o;
  logic        left_valid_o, right_valid_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] lq[$], rq[$];

  always #10 clk = ~clk;

  pcm_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i(fmt), .dsp_late_i(late), .len_sel_i(len_sel),
    .left_o(left_o), .left_valid_o(left_valid_o),
    .right_o(right_o), .right_valid_o(right_valid_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (left_valid_o)  lq.push_back(left_o);
    if (right_valid_o) rq.push_back(right_o);
    if (left_valid_o && right_valid_o) begin
      checks++; fails++;
      $display("FAIL R8 both strobes high: actual 1 expected 0");
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_period(input logic w, input logic d);
    @(negedge clk);
    sck = 1'b0; ws = w; sd = d;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  function automatic string req_of(input int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_case(input int f, input int lt, input int ls, input int slots, input int seed);
    int wl;
    logic [63:0] smp [2][2];
    logic [31:0] exp [2][2];
    string tag;
    wl = 16 + 4 * ls + ((ls == 3) ? 4 : 0);
    fmt = 2'(f); late = lt[0]; len_sel = 2'(ls);
    tag = $sformatf("%s R6%s fmt=%0d late=%0d wl=%0d slots=%0d", req_of(f),
                    (slots > wl + 1) ? " R7" : "", f, lt, wl, slots);
    for (int k = 0; k < 3; k++) bit_period((f == 3) ? 1'b0 : 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    lq.delete(); rq.delete();
    for (int fr = 0; fr < 2; fr++)
      for (int c = 0; c < 2; c++) begin
        smp[fr][c] = (64'(32'hA5C3_0F96 ^ (seed * 32'h9E37_79B9) ^ (fr * 32'h1357_9BDF)
                     ^ (c * 32'hF0F0_3C3C))) & ((64'd1 << wl) - 64'd1);
        exp[fr][c] = 32'(smp[fr][c] << (32 - wl));
      end
    for (int fr = 0; fr < 2; fr++) begin
      if (f != 3) begin
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < slots; k++) begin
            int idx;
            idx = (f == 0) ? k : (f == 2) ? k - 1 : k - (slots - wl);
            bit_period(h[0], (idx >= 0 && idx < wl) ? smp[fr][h][wl-1-idx] : 1'b1);
          end
      end else begin
        for (int k = 0; k < 2 * slots; k++) begin
          int idx;
          logic b;
          idx = k - lt;
          if (idx >= 0 && idx < wl)           b = smp[fr][0][wl-1-idx];
          else if (idx >= wl && idx < 2 * wl) b = smp[fr][1][wl-1-(idx-wl)];
          else                                b = 1'b1;
          bit_period(k == 0, b);
        end
      end
    end
    for (int k = 0; k < 2; k++) bit_period(1'b0, 1'b0);
    repeat (10) @(negedge clk);
    // right-aligned: the edge into the first left half also closes the preamble half
    if (f == 1 && rq.size() == 3) void'(rq.pop_front());
    chk({"R8 R9 left count ", tag}, 32'(lq.size()), 32'd2);
    chk({"R8 R9 right count ", tag}, 32'(rq.size()), 32'd2);
    for (int fr = 0; fr < 2; fr++) begin
      chk({"left ", tag},  (lq.size() > fr) ? lq[fr] : 32'hDEAD_BEEF, exp[fr][0]);
      chk({"right ", tag}, (rq.size() > fr) ? rq[fr] : 32'hDEAD_BEEF, exp[fr][1]);
    end
  endtask

  initial begin
    int seed = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 left_o after reset", left_o, 32'd0);
    chk("R1 right_o after reset", right_o, 32'd0);
    chk("R1 strobes after reset", {30'd0, left_valid_o, right_valid_o}, 32'd0);
    for (int f = 0; f < 4; f++)
      for (int lt = 0; lt < ((f == 3) ? 2 : 1); lt++)
        for (int ls = 0; ls < 4; ls++)
          for (int sv = 0; sv < 2; sv++) begin
            int wl;
            wl = 16 + 4 * ls + ((ls == 3) ? 4 : 0);
            run_case(f, lt, ls, (sv == 0) ? wl + 1 : 40, seed);
            seed++;
          end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule